// File: doc/BRIEF.md
# Packed Alternating Double-Precision Add/Subtract Unit

This unit takes two 256-bit vectors, each holding four IEEE-754 double-precision values. It computes one result per 64-bit lane. Lanes with an even index compute the first operand minus the second. Lanes with an odd index compute the first operand plus the second. Each lane shares one double-precision adder. For subtraction, the adder receives the second operand with its sign bit inverted. Every lane rounds to nearest, ties to even.

A two-bit mode input sets how the upper 128 bits are handled:

- **Legacy-128 (0):** the first source is also the destination, so its upper half passes through unchanged.
- **Compact-128 (1):** the upper half is cleared.
- **Wide-256 (2):** all four lanes are computed.

Results are registered one edge after `valid_i`, together with an output strobe. Five exception flags are collected from the active lanes and held until a clear. In legacy-128 mode, a misaligned memory operand raises a fault and blocks the write.

Top module: `asu_top`

## Requirements
- R1: Lanes 0 and 2 produce src1 − src2 and lanes 1 and 3 produce src1 + src2. Each result is correctly rounded to nearest-even in the IEEE-754 binary64 format.
- R2: `res_o`, `fault_o` and new flag bits update on the rising edge after an edge where `valid_i` is high. `valid_o` is high exactly on the cycle after `valid_i` was high. `res_o` holds its value when `valid_i` is low.
- R3: In mode 0 (legacy-128), `res_o[255:128]` equals `src1_i[255:128]` of the same transaction.
- R4: In mode 1 (compact-128), `res_o[255:128]` is zero.
- R5: In mode 2 (wide-256), all four lanes hold computed results.
- R6: An exact zero from effective subtraction of equal magnitudes is +0. The sum of two zeros of the same sign keeps that sign.
- R7: A NaN operand yields a quiet NaN, with bit 51 set. If the first operand is a NaN it is returned, otherwise the second operand is returned with its own sign. A signalling NaN, meaning bit 51 is clear, sets invalid (flag bit 0).
- R8: An infinity combined with an opposite-signed infinity after the lane's sign inversion yields 0xFFF8000000000000 and sets invalid (bit 0).
- R9: A finite result whose rounded magnitude exceeds the largest finite value becomes a signed infinity. It sets overflow (bit 2) and inexact (bit 4).
- R10: A nonzero result below the smallest normal magnitude sets underflow (bit 3). A subnormal operand in an active lane sets denormal (bit 1).
- R11: A result that differs from the exact sum sets inexact (bit 4).
- R12: `flags_o` is the OR of the flags of every active lane across accepted transactions since the last `clr_flags_i`. Upper lanes in the 128-bit modes contribute nothing. A clear with a transaction in the same cycle keeps only that transaction's flags.
- R13: In mode 0, when `mem_op_i` is high and `addr_lo_i` is nonzero, `fault_o` rises with `valid_o`, `res_o` equals `src1_i` unchanged, and no flags are added. Modes 1 and 2 never fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Transaction accepted this cycle |
| mode_i | input | 2 | 0 legacy-128, 1 compact-128, 2 wide-256 |
| src1_i | input | 256 | First source (old destination in mode 0) |
| src2_i | input | 256 | Second source |
| mem_op_i | input | 1 | Second source comes from memory |
| addr_lo_i | input | 4 | Low address bits of the memory operand |
| clr_flags_i | input | 1 | Clear the sticky flags |
| res_o | output | 256 | Registered result |
| valid_o | output | 1 | Result strobe |
| fault_o | output | 1 | Alignment fault strobe |
| flags_o | output | 5 | Sticky flags {inexact, underflow, overflow, denormal, invalid} |

## Verification
The stimulus uses:

- **Hand-picked exact sums:** these separate the subtract lanes from the add lanes.
- **Values like 0.1 + 0.2:** these show that round-to-nearest-even differs from truncation.
- **Random operands with close exponents:** these cause deep cancellation and long normalisation shifts.
- **Random operands with wide exponent spread:** these exercise the sticky-bit alignment path.

Dedicated patterns cover the following cases:

- A difference of one ulp at the normal boundary, which gives a subnormal result.
- Maximum plus maximum, which overflows.
- Signalling and quiet NaNs placed in either operand.
- Opposite infinities.
- Overflowing values placed in inactive upper lanes, to show they add no flags.
- The same stimulus run in each mode, to show keep, zero and compute behaviour for the upper half.

// File: rtl/asu_pkg.sv
package asu_pkg;

  localparam int FP_W  = 64;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;

  typedef enum logic [1:0] {
    MODE_L128 = 2'd0,
    MODE_V128 = 2'd1,
    MODE_V256 = 2'd2
  } asu_mode_e;

  // bit0 invalid, bit1 denormal, bit2 overflow, bit3 underflow, bit4 inexact
  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fp_flags_t;

  typedef struct packed {
    logic [FP_W-1:0] res;
    fp_flags_t       flags;
  } lane_out_t;

  localparam logic [FP_W-1:0] DEF_QNAN = 64'hFFF8_0000_0000_0000;
  localparam logic [FP_W-1:0] QUIET_BIT = 64'h0008_0000_0000_0000;

  function automatic logic is_nan(input logic [FP_W-1:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != '0);
  endfunction

  function automatic logic is_inf(input logic [FP_W-1:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] == '0);
  endfunction

  function automatic logic is_sub(input logic [FP_W-1:0] x);
    return (x[62:52] == '0) && (x[51:0] != '0);
  endfunction

  // One binary64 add (sub=0) or subtract (sub=1), round to nearest even.
  function automatic lane_out_t fp64_addsub(input logic [FP_W-1:0] a,
                                            input logic [FP_W-1:0] b,
                                            input logic            sub);
    lane_out_t       o;
    logic [FP_W-1:0] be, big, sml;
    logic            eff_sub, tiny, up;
    logic [11:0]     eb, es, d, e;
    logic [55:0]     xl, xs, nrm, lost_mask;
    logic [56:0]     sum;
    logic [53:0]     rm;
    o  = '0;
    be = {b[63] ^ sub, b[62:0]};
    o.flags.denormal = is_sub(a) || is_sub(b);
    if (is_nan(a) || is_nan(b)) begin
      o.res = is_nan(a) ? (a | QUIET_BIT) : (b | QUIET_BIT);
      o.flags.invalid = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    end else if (is_inf(a) && is_inf(be)) begin
      if (a[63] != be[63]) begin
        o.res = DEF_QNAN;
        o.flags.invalid = 1'b1;
      end else begin
        o.res = a;
      end
    end else if (is_inf(a)) begin
      o.res = a;
    end else if (is_inf(be)) begin
      o.res = be;
    end else begin
      big = (be[62:0] > a[62:0]) ? be : a;
      sml = (be[62:0] > a[62:0]) ? a : be;
      eb  = (big[62:52] == '0) ? 12'd1 : {1'b0, big[62:52]};
      es  = (sml[62:52] == '0) ? 12'd1 : {1'b0, sml[62:52]};
      xl  = {big[62:52] != '0, big[51:0], 3'b000};
      xs  = {sml[62:52] != '0, sml[51:0], 3'b000};
      d   = eb - es;
      if (d >= 12'd56) begin
        xs = {55'b0, |xs};
      end else begin
        lost_mask = (56'd1 << d[5:0]) - 56'd1;
        xs = (xs >> d[5:0]) | {55'b0, |(xs & lost_mask)};
      end
      eff_sub = a[63] ^ be[63];
      e = eb;
      if (!eff_sub) begin
        sum = {1'b0, xl} + {1'b0, xs};
        if (sum[56]) begin
          nrm = sum[56:1] | {55'b0, sum[0]};
          e   = e + 12'd1;
        end else begin
          nrm = sum[55:0];
        end
      end else begin
        sum = {1'b0, xl} - {1'b0, xs};
        nrm = sum[55:0];
        for (int i = 0; i < 55; i++) begin
          if (!nrm[55] && e > 12'd1) begin
            nrm = nrm << 1;
            e   = e - 12'd1;
          end
        end
      end
      if (nrm == '0) begin
        o.res = eff_sub ? 64'd0 : {big[63], 63'd0};
      end else begin
        tiny = (e == 12'd1) && !nrm[55];
        up   = nrm[2] & (nrm[3] | nrm[1] | nrm[0]);
        rm   = {1'b0, nrm[55:3]} + {53'd0, up};
        if (rm[53]) begin
          rm = rm >> 1;
          e  = e + 12'd1;
        end
        if (e >= 12'd2047) begin
          o.res = {big[63], 11'h7FF, 52'd0};
          o.flags.overflow = 1'b1;
          o.flags.inexact  = 1'b1;
        end else begin
          o.res = {big[63], (e == 12'd1 && !rm[52]) ? 11'd0 : e[10:0], rm[51:0]};
          o.flags.inexact   = |nrm[2:0];
          o.flags.underflow = tiny;
        end
      end
    end
    return o;
  endfunction

endpackage

// File: rtl/asu_lane.sv
module asu_lane
  import asu_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] res_o,
  output fp_flags_t       flags_o
);
  localparam logic DO_SUB = (LANE_IDX % 2) == 0;

  lane_out_t lane_q;

  always_comb begin
    lane_q  = fp64_addsub(a_i, b_i, DO_SUB);
    res_o   = lane_q.res;
    flags_o = lane_q.flags;
  end
endmodule

// File: rtl/asu_merge.sv
module asu_merge
  import asu_pkg::*;
#(
  parameter int HALF_W = 128
) (
  input  logic [1:0]        mode_i,
  input  logic [HALF_W-1:0] old_hi_i,
  input  logic [HALF_W-1:0] calc_hi_i,
  output logic [HALF_W-1:0] hi_o
);
  always_comb begin
    unique case (mode_i)
      MODE_L128: hi_o = old_hi_i;
      MODE_V256: hi_o = calc_hi_i;
      default:   hi_o = '0;
    endcase
  end
endmodule

// File: rtl/asu_top.sv
module asu_top
  import asu_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int ALIGN_BITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  valid_i,
  input  logic [1:0]            mode_i,
  input  logic [LANES*64-1:0]   src1_i,
  input  logic [LANES*64-1:0]   src2_i,
  input  logic                  mem_op_i,
  input  logic [ALIGN_BITS-1:0] addr_lo_i,
  input  logic                  clr_flags_i,
  output logic [LANES*64-1:0]   res_o,
  output logic                  valid_o,
  output logic                  fault_o,
  output logic [4:0]            flags_o
);
  localparam int VEC_W      = LANES * FP_W;
  localparam int HALF_LANES = LANES / 2;
  localparam int HALF_W     = HALF_LANES * FP_W;

  logic [FP_W-1:0]  lane_res [LANES];
  fp_flags_t        lane_flg [LANES];
  logic [VEC_W-1:0] lanes_flat;
  logic [LANES-1:0] act_mask;
  fp_flags_t        flags_new;
  logic             fault_now;
  logic [HALF_W-1:0] upper_sel;
  logic [VEC_W-1:0] res_next;
  fp_flags_t        flags_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    asu_lane #(.LANE_IDX(g)) u_lane (
      .a_i     (src1_i[g*FP_W +: FP_W]),
      .b_i     (src2_i[g*FP_W +: FP_W]),
      .res_o   (lane_res[g]),
      .flags_o (lane_flg[g])
    );
    assign lanes_flat[g*FP_W +: FP_W] = lane_res[g];
    assign act_mask[g] = (g < HALF_LANES) || (mode_i == MODE_V256);
  end

  always_comb begin
    flags_new = '0;
    for (int i = 0; i < LANES; i++) begin
      if (act_mask[i]) flags_new = flags_new | lane_flg[i];
    end
  end

  asu_merge #(.HALF_W(HALF_W)) u_merge (
    .mode_i    (mode_i),
    .old_hi_i  (src1_i[VEC_W-1:HALF_W]),
    .calc_hi_i (lanes_flat[VEC_W-1:HALF_W]),
    .hi_o      (upper_sel)
  );

  assign fault_now = valid_i && (mode_i == MODE_L128) && mem_op_i && (addr_lo_i != '0);
  assign res_next  = fault_now ? src1_i : {upper_sel, lanes_flat[HALF_W-1:0]};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_o   <= '0;
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      flags_q <= '0;
    end else begin
      valid_o <= valid_i;
      fault_o <= fault_now;
      if (valid_i) res_o <= res_next;
      flags_q <= (clr_flags_i ? fp_flags_t'('0) : flags_q)
               | ((valid_i && !fault_now) ? flags_new : fp_flags_t'('0));
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int VEC_W  = 256,
  parameter int HALF_W = 128
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             valid_i,
  input logic [1:0]       mode_i,
  input logic [VEC_W-1:0] src1_i,
  input logic             clr_flags_i,
  input logic             fault_now,
  input logic [4:0]       flags_new,
  input logic [VEC_W-1:0] res_o,
  input logic             valid_o,
  input logic             fault_o,
  input logic [4:0]       flags_o
);
  assert_valid_rise_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> !valid_o && $stable(res_o));
  assert_keep_upper_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i && mode_i == 2'd0 |=> res_o[VEC_W-1:HALF_W] == $past(src1_i[VEC_W-1:HALF_W]));
  assert_zero_upper_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i && mode_i == 2'd1 |=> res_o[VEC_W-1:HALF_W] == '0);
  assert_quiet_nan_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o && !fault_o && res_o[62:52] == 11'h7FF && res_o[51:0] != '0 |-> res_o[51]);
  assert_overflow_inexact_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    flags_new[2] |-> flags_new[4]);
  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_flags_i |=> ($past(flags_o) & ~flags_o) == 5'd0);
  assert_fault_hold_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_now |=> fault_o && res_o == $past(src1_i));
  assert_fault_noflag_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_now && !clr_flags_i |=> flags_o == $past(flags_o));
  assert_fault_mode_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i && mode_i != 2'd0 |=> !fault_o);
endmodule

bind asu_top asu_checker #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .valid_i     (valid_i),
  .mode_i      (mode_i),
  .src1_i      (src1_i),
  .clr_flags_i (clr_flags_i),
  .fault_now   (fault_now),
  .flags_new   (flags_new),
  .res_o       (res_o),
  .valid_o     (valid_o),
  .fault_o     (fault_o),
  .flags_o     (flags_o)
);

// File: tb/asu_top_bench.sv
module asu_top_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [255:0] src1_i = '0, src2_i = '0;
  logic         mem_op_i = 1'b0;
  logic [3:0]   addr_lo_i = '0;
  logic         clr_flags_i = 1'b0;
  logic [255:0] res_o;
  logic         valid_o, fault_o;
  logic [4:0]   flags_o;

  asu_top u_asu_top (
    .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .mode_i(mode_i),
    .src1_i(src1_i), .src2_i(src2_i), .mem_op_i(mem_op_i),
    .addr_lo_i(addr_lo_i), .clr_flags_i(clr_flags_i),
    .res_o(res_o), .valid_o(valid_o), .fault_o(fault_o), .flags_o(flags_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [255:0] q_res[$];
  logic [4:0]   q_flg[$];
  logic         q_flt[$];
  int           q_cyc[$];
  string        q_tag[$];
  logic [4:0]   exp_flags = '0;

  function automatic logic nan64(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction
  function automatic logic inf64(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] == 0;
  endfunction

  // Reference: host real arithmetic for finite values, rules for specials.
  task automatic ref_lane(input logic [63:0] a, input logic [63:0] b, input bit sub,
                          output logic [63:0] r, output logic [4:0] fl);
    real ra, rb, rbe, s, z, err;
    logic sbe;
    fl = '0;
    fl[1] = (a[62:52] == 0 && a[51:0] != 0) || (b[62:52] == 0 && b[51:0] != 0);
    sbe = b[63] ^ sub;
    if (nan64(a) || nan64(b)) begin
      r = nan64(a) ? {a[63:52], 1'b1, a[50:0]} : {b[63:52], 1'b1, b[50:0]};
      fl[0] = (nan64(a) && !a[51]) || (nan64(b) && !b[51]);
    end else if (inf64(a) && inf64(b)) begin
      if (a[63] != sbe) begin r = 64'hFFF8_0000_0000_0000; fl[0] = 1; end
      else r = a;
    end else if (inf64(a)) r = a;
    else if (inf64(b)) r = {sbe, b[62:0]};
    else begin
      ra = $bitstoreal(a); rb = $bitstoreal(b);
      rbe = sub ? -rb : rb;
      s = ra + rbe;
      r = $realtobits(s);
      if (r[62:52] == 11'h7FF) begin
        fl[2] = 1; fl[4] = 1;
      end else begin
        z = s - ra;
        err = (ra - (s - z)) + (rbe - z);
        fl[4] = (err != 0.0);
        fl[3] = (r[62:52] == 0 && r[51:0] != 0);
      end
    end
  endtask

  task automatic send(input logic [1:0] m, input logic [255:0] s1, input logic [255:0] s2,
                      input logic mem, input logic [3:0] adr, input logic clr, input string tag);
    logic [63:0]  lr [4];
    logic [4:0]   lf [4];
    logic [255:0] er;
    logic [4:0]   nf;
    logic         flt;
    @(negedge clk);
    valid_i = 1; mode_i = m; src1_i = s1; src2_i = s2;
    mem_op_i = mem; addr_lo_i = adr; clr_flags_i = clr;
    for (int i = 0; i < 4; i++) ref_lane(s1[i*64 +: 64], s2[i*64 +: 64], (i % 2) == 0, lr[i], lf[i]);
    flt = (m == 2'd0) && mem && (adr != 0);
    nf = lf[0] | lf[1] | ((m == 2'd2) ? (lf[2] | lf[3]) : 5'd0);
    if (m == 2'd0)      er = {s1[255:128], lr[1], lr[0]};
    else if (m == 2'd1) er = {128'd0, lr[1], lr[0]};
    else                er = {lr[3], lr[2], lr[1], lr[0]};
    if (flt) er = s1;
    if (clr) exp_flags = '0;
    if (!flt) exp_flags = exp_flags | nf;
    q_res.push_back(er); q_flg.push_back(exp_flags); q_flt.push_back(flt);
    q_cyc.push_back(cyc); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 0; clr_flags_i = 0; mem_op_i = 0;
  endtask

  // Monitor: pop and compare each result as it appears.
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (q_res.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: unexpected valid_o, actual=1 expected=0");
      end else begin
        logic [255:0] er; logic [4:0] ef; logic eflt; int ec; string t;
        er = q_res.pop_front(); ef = q_flg.pop_front(); eflt = q_flt.pop_front();
        ec = q_cyc.pop_front(); t = q_tag.pop_front();
        checks++;
        if (res_o !== er) begin errors++;
          $display("FAIL %s: res actual=%h expected=%h", t, res_o, er); end
        checks++;
        if (flags_o !== ef) begin errors++;
          $display("FAIL %s: flags actual=%b expected=%b", t, flags_o, ef); end
        checks++;
        if (fault_o !== eflt || cyc != ec + 1) begin errors++;
          $display("FAIL %s (R2/R13): fault/cycle actual=%b/%0d expected=%b/%0d", t, fault_o, cyc, eflt, ec + 1); end
      end
    end
  end

  function automatic logic [63:0] rnd_fp(input int spread);
    logic [63:0] x; int ex;
    ex = 1023 + int'($urandom % (2 * spread + 1)) - spread;
    x = {$urandom, $urandom};
    x[62:52] = ex[10:0];
    return x;
  endfunction

  function automatic logic [255:0] v4(input real a, input real b, input real c, input real d);
    return {$realtobits(d), $realtobits(c), $realtobits(b), $realtobits(a)};
  endfunction

  localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;  // reset state
    if (res_o !== '0 || valid_o !== 0 || fault_o !== 0 || flags_o !== 0) begin
      errors++; $display("FAIL R2: reset state actual=%h/%b/%b/%b expected=0", res_o, valid_o, fault_o, flags_o);
    end
    // R1, R3: legacy mode, exact sums, upper half kept
    send(2'd0, v4(1.5, 2.25, 7.0, -9.5), v4(0.5, 1.0, 3.0, 3.0), 0, 0, 1, "R1_R3");
    // R4, R11: compact mode, 0.1/0.2 rounding, upper cleared
    send(2'd1, v4(0.3, 0.1, 5.0, 6.0), v4(0.1, 0.2, 1.0, 1.0), 0, 0, 1, "R4_R11");
    // R5, R6: wide mode, cancellation to +0 and same-sign zeros
    send(2'd2, v4(3.0, -0.0, -4.0, 1.0e300), v4(3.0, -0.0, 2.5, 1.0e300), 0, 0, 1, "R5_R6");
    // R9: overflow in lane 1
    send(2'd2, {64'd0, 64'd0, MAXF, 64'd0}, {64'd0, 64'd0, MAXF, 64'd0}, 0, 0, 1, "R9");
    // R10: subnormal result and subnormal operand
    send(2'd1, {128'd0, 64'd0, 64'h0010_0000_0000_0000}, {128'd0, 64'd0, 64'h000F_FFFF_FFFF_FFFF}, 0, 0, 1, "R10");
    // R7: quiet NaN in a, signalling NaN in b
    send(2'd1, {128'd0, $realtobits(1.0), 64'h7FF8_0000_0000_0001},
               {128'd0, 64'hFFF0_0000_0000_0005, $realtobits(2.0)}, 0, 0, 1, "R7");
    // R8: opposite infinities after sign inversion
    send(2'd1, {128'd0, PINF, PINF}, {128'd0, NINF, PINF}, 0, 0, 1, "R8");
    // R12: overflowing values in inactive upper lanes add no flags
    send(2'd1, {MAXF, MAXF, $realtobits(1.0), $realtobits(1.0)}, {MAXF, MAXF, $realtobits(1.0), $realtobits(1.0)}, 0, 0, 1, "R12_inactive");
    // R12: sticky across transactions
    send(2'd1, v4(0.1, 0.2, 0.0, 0.0), v4(0.7, 0.3, 0.0, 0.0), 0, 0, 1, "R12_set");
    send(2'd1, v4(2.0, 2.0, 0.0, 0.0), v4(1.0, 1.0, 0.0, 0.0), 0, 0, 0, "R12_sticky");
    idle();
    // R13: misaligned legacy memory operand faults, compact does not
    send(2'd0, v4(0.1, 0.2, 9.0, 8.0), v4(MAXF == 0 ? 0.0 : 1.0e308, 1.0e308, 1.0, 1.0), 1, 4'd8, 0, "R13_fault");
    send(2'd1, v4(0.1, 0.2, 9.0, 8.0), v4(1.0, 1.0, 1.0, 1.0), 1, 4'd8, 0, "R13_vex");
    send(2'd0, v4(4.0, 4.0, 9.0, 8.0), v4(1.0, 1.0, 1.0, 1.0), 1, 4'd0, 1, "R13_aligned");
    idle();
    // R1: random, close exponents then wide spread, back to back (R2)
    for (int k = 0; k < 60; k++) begin
      int sp;
      sp = (k < 30) ? 2 : 60;
      send(2'd2, {rnd_fp(sp), rnd_fp(sp), rnd_fp(sp), rnd_fp(sp)},
                 {rnd_fp(sp), rnd_fp(sp), rnd_fp(sp), rnd_fp(sp)}, 0, 0, 1, "R1_rand");
    end
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (q_res.size() != 0) begin
      errors++; $display("FAIL R2: results missing actual=%0d expected=0 pending", q_res.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R2: watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule